// File: doc/BRIEF.md
# CAN Frame Tail and Acknowledge Tracker

This block follows the fixed-form end of a CAN data or remote frame. It starts at the bit after the last CRC bit and ends when interframe spacing is complete. A neighbouring receive path has already removed stuff bits and computed the CRC. That path raises `crc_done` once the CRC sequence has been taken in. It also reports whether the CRC matched and whether this node sent the frame. After that, the tracker consumes one sampled bus level per `bit_valid` strobe. Unstuffed bits follow in a fixed order: CRC delimiter, ACK slot, ACK delimiter, seven end-of-frame bits, then three intermission bits.

When the node is a receiver and the CRC matched, the tracker pulls `ack_drive` high for exactly the ACK slot, so the bus shows a dominant bit there. In every role it judges the acknowledge from three bits: the slot and the two recessive delimiters on either side of it. It emits one verdict pulse. A transmitter that sees no acknowledge also flags an acknowledge error and abandons the tail. A correct tail ends in a frame-done pulse, and `bus_idle` returns once intermission is over, so a new start of frame may be accepted.

Bus levels on `rx_bit` are 1 for recessive and 0 for dominant.

Top module: `can_tail_checker`

## Requirements
- R1: During and after a synchronous active-low reset, `bus_idle` is 1 and `ack_drive`, `ack_seen`, `ack_missing`, `ack_err`, `form_err` and `frame_done` are 0.
- R2: A dominant level sampled as the CRC delimiter (first strobe after `crc_done`) gives a one-cycle `form_err`, no verdict pulse and no acknowledge drive, and `bus_idle` returns in the same cycle.
- R3: With `crc_match`=1 and `is_sender`=0, `ack_drive` goes high in the cycle after a recessive CRC delimiter strobe. It stays high until the ACK slot strobe and is 0 from the cycle after it. With `crc_match`=0 or `is_sender`=1, `ack_drive` stays 0.
- R4: A recessive CRC delimiter, dominant slot and recessive ACK delimiter give a one-cycle `ack_seen` in the cycle after the ACK delimiter strobe.
- R5: Recessive CRC delimiter, slot and ACK delimiter give a one-cycle `ack_missing` in the cycle after the ACK delimiter strobe.
- R6: A dominant ACK delimiter gives `form_err` instead of any verdict pulse and ends the tail.
- R7: For a sender (`is_sender`=1), a missing acknowledge raises `ack_err` together with `ack_missing`. The tail then ends with no `frame_done`, and `bus_idle` returns in the same cycle.
- R8: A dominant level on any of the seven end-of-frame strobes gives `form_err` in the cycle after that strobe, ends the tail and suppresses `frame_done`.
- R9: `frame_done` pulses for one cycle, in the cycle after the seventh recessive end-of-frame strobe, and at no other time.
- R10: `bus_idle` is 0 from the cycle after `crc_done` is taken. It returns to 1 in the cycle after the third intermission strobe. The levels sampled during intermission have no effect.
- R11: Without `bit_valid` the tracker does not advance, whatever `rx_bit` does.
- R12: `crc_done` is ignored while a tail is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_done | input | 1 | Pulse: CRC sequence received, tail begins |
| crc_match | input | 1 | CRC matched, sampled with `crc_done` |
| is_sender | input | 1 | This node transmitted the frame, sampled with `crc_done` |
| bit_valid | input | 1 | One-cycle sample strobe per bit time |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| ack_drive | output | 1 | 1 = drive dominant onto the bus (ACK slot) |
| ack_seen | output | 1 | Pulse: acknowledge detected |
| ack_missing | output | 1 | Pulse: no acknowledge detected |
| ack_err | output | 1 | Pulse: sender got no acknowledge |
| form_err | output | 1 | Pulse: dominant bit in a fixed recessive position |
| frame_done | output | 1 | Pulse: end of frame reached cleanly |
| bus_idle | output | 1 | Level: no tail in progress, new frame may start |

## Verification
A phase register stuck or skipping shows up at the ports within one or two bit strobes. The acknowledge drive appears in the wrong bit, the verdict pulse lands on the wrong strobe, or `frame_done` and `bus_idle` rise at the wrong bit index. The bench records the strobe index at which each pulse and the idle return appear and compares them with the index the requirements give. An off-by-one in the end-of-frame or intermission count is therefore caught one strobe early or late. Toggling `rx_bit` between strobes exposes any logic that samples without the strobe.

// File: rtl/can_tail_pkg.sv
// Shared types for the CAN frame tail tracker.
// Assumes bus level 1 = recessive, 0 = dominant.
package can_tail_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CDEL = 3'd1,
        PH_SLOT = 3'd2,
        PH_ADEL = 3'd3,
        PH_EOF  = 3'd4,
        PH_IFS  = 3'd5
    } tail_phase_t;

    typedef enum logic [1:0] {
        VD_ACK  = 2'd0,
        VD_NACK = 2'd1,
        VD_FORM = 2'd2
    } ack_verdict_t;

endpackage

// File: rtl/tail_field_counter.sv
// Bit counter for the multi-bit tail fields (end of frame, intermission).
// Assumes clear has priority over step; counts strobes only.
module tail_field_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    // Hold, clear or advance the field bit count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/tail_ack_classify.sv
// Judges the acknowledge from CRC delimiter, ACK slot and ACK delimiter.
// Pure combinational; inputs are bus levels (1 recessive) except slot_dom.
module tail_ack_classify
    import can_tail_pkg::*;
(
    input  logic         cdel_rec,
    input  logic         slot_dom,
    input  logic         adel_rec,
    output ack_verdict_t verdict
);

    // Either delimiter dominant is a form fault, else the slot decides.
    always_comb begin
        if (!cdel_rec || !adel_rec)
            verdict = VD_FORM;
        else if (slot_dom)
            verdict = VD_ACK;
        else
            verdict = VD_NACK;
    end

endmodule

// File: rtl/tail_ack_driver.sv
// Holds the dominant request for the ACK slot.
// Assumes set and clear never coincide (they belong to different phases).
module tail_ack_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic drive
);

    // Raise at the CRC delimiter strobe, drop at the ACK slot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drive <= 1'b0;
        else if (clear)
            drive <= 1'b0;
        else if (set)
            drive <= 1'b1;
    end

endmodule

// File: rtl/can_tail_checker.sv
// CAN frame tail tracker: walks the unstuffed bits from the CRC delimiter
// through intermission, drives the ACK slot as receiver, classifies the
// acknowledge, flags form faults and reports frame end and bus idle.
// Assumes destuffed input, one bit_valid strobe per bit time, crc_done pulse
// after the last CRC bit. Error frames are handled elsewhere: after a fault
// the tracker simply returns to idle.
module can_tail_checker
    import can_tail_pkg::*;
#(
    parameter int EOF_BITS = 7,
    parameter int IFS_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_done,
    input  logic crc_match,
    input  logic is_sender,
    input  logic bit_valid,
    input  logic rx_bit,
    output logic ack_drive,
    output logic ack_seen,
    output logic ack_missing,
    output logic ack_err,
    output logic form_err,
    output logic frame_done,
    output logic bus_idle
);

    localparam int CNT_MAX = (EOF_BITS > IFS_BITS) ? EOF_BITS : IFS_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(EOF_BITS - 1);
    localparam logic [CNT_W-1:0] IFS_LAST = CNT_W'(IFS_BITS - 1);

    tail_phase_t      phase;
    logic             sender_q;
    logic             match_q;
    logic             cdel_q;
    logic             slot_dom_q;
    logic [CNT_W-1:0] field_cnt;
    logic             cnt_clear;
    logic             cnt_step;
    logic             drv_set;
    logic             drv_clear;
    ack_verdict_t     verdict;

    // Counter restarts on entry to end-of-frame and to intermission.
    always_comb begin
        cnt_clear = bit_valid && ((phase == PH_ADEL) ||
                                  (phase == PH_EOF && field_cnt == EOF_LAST));
        cnt_step  = bit_valid && (phase == PH_EOF || phase == PH_IFS);
    end

    tail_field_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .step  (cnt_step),
        .count (field_cnt)
    );

    tail_ack_classify u_cls (
        .cdel_rec (cdel_q),
        .slot_dom (slot_dom_q),
        .adel_rec (rx_bit),
        .verdict  (verdict)
    );

    // Acknowledge request: matched receiver only, for the slot bit alone.
    always_comb begin
        drv_set   = bit_valid && (phase == PH_CDEL) && rx_bit && match_q && !sender_q;
        drv_clear = bit_valid && (phase == PH_SLOT);
    end

    tail_ack_driver u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (drv_set),
        .clear (drv_clear),
        .drive (ack_drive)
    );

    // Phase sequencer with one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            sender_q    <= 1'b0;
            match_q     <= 1'b0;
            cdel_q      <= 1'b1;
            slot_dom_q  <= 1'b0;
            ack_seen    <= 1'b0;
            ack_missing <= 1'b0;
            ack_err     <= 1'b0;
            form_err    <= 1'b0;
            frame_done  <= 1'b0;
            bus_idle    <= 1'b1;
        end else begin
            ack_seen    <= 1'b0;
            ack_missing <= 1'b0;
            ack_err     <= 1'b0;
            form_err    <= 1'b0;
            frame_done  <= 1'b0;
            case (phase)
                PH_IDLE: if (crc_done) begin
                    phase    <= PH_CDEL;
                    sender_q <= is_sender;
                    match_q  <= crc_match;
                    bus_idle <= 1'b0;
                end
                PH_CDEL: if (bit_valid) begin
                    cdel_q <= rx_bit;
                    if (!rx_bit) begin
                        form_err <= 1'b1;
                        phase    <= PH_IDLE;
                        bus_idle <= 1'b1;
                    end else begin
                        phase <= PH_SLOT;
                    end
                end
                PH_SLOT: if (bit_valid) begin
                    slot_dom_q <= !rx_bit;
                    phase      <= PH_ADEL;
                end
                PH_ADEL: if (bit_valid) begin
                    case (verdict)
                        VD_ACK: begin
                            ack_seen <= 1'b1;
                            phase    <= PH_EOF;
                        end
                        VD_NACK: begin
                            ack_missing <= 1'b1;
                            if (sender_q) begin
                                ack_err  <= 1'b1;
                                phase    <= PH_IDLE;
                                bus_idle <= 1'b1;
                            end else begin
                                phase <= PH_EOF;
                            end
                        end
                        default: begin
                            form_err <= 1'b1;
                            phase    <= PH_IDLE;
                            bus_idle <= 1'b1;
                        end
                    endcase
                end
                PH_EOF: if (bit_valid) begin
                    if (!rx_bit) begin
                        form_err <= 1'b1;
                        phase    <= PH_IDLE;
                        bus_idle <= 1'b1;
                    end else if (field_cnt == EOF_LAST) begin
                        frame_done <= 1'b1;
                        phase      <= PH_IFS;
                    end
                end
                PH_IFS: if (bit_valid && field_cnt == IFS_LAST) begin
                    phase    <= PH_IDLE;
                    bus_idle <= 1'b1;
                end
                default: begin
                    phase    <= PH_IDLE;
                    bus_idle <= 1'b1;
                end
            endcase
        end
    end

    AST_DRIVE_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> (phase == PH_SLOT)); // R3
    AST_SINGLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_seen, ack_missing, form_err})); // R6
    AST_ACKERR_IMPLIES_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (ack_missing && bus_idle)); // R7
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!form_err && !ack_err && phase == PH_IFS)); // R9
    AST_IDLE_OUTSIDE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !bus_idle); // R10
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && phase != PH_IDLE) |=> $stable(phase)); // R11
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EOF) |-> (field_cnt <= EOF_LAST)); // R8

endmodule

// File: tb/tb_can_tail_checker.sv
// Self-checking bench: table of frame tails walked by one loop, then
// directed tests for reset and re-arm corner cases.
module tb_can_tail_checker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crc_done = 1'b0, crc_match = 1'b0, is_sender = 1'b0;
    logic bit_valid = 1'b0;
    logic drv_bit = 1'b1;
    logic rx_bit;
    logic ack_drive, ack_seen, ack_missing, ack_err, form_err, frame_done, bus_idle;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    // Wired-AND bus: the design's own dominant drive overrides the bench level.
    assign rx_bit = drv_bit & ~ack_drive;

    can_tail_checker dut (
        .clk(clk), .rst_n(rst_n), .crc_done(crc_done), .crc_match(crc_match),
        .is_sender(is_sender), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .ack_drive(ack_drive), .ack_seen(ack_seen), .ack_missing(ack_missing),
        .ack_err(ack_err), .form_err(form_err), .frame_done(frame_done),
        .bus_idle(bus_idle)
    );

    // Entry: {sender, match, bits[12:0] (bit0 = CRC delimiter, 1 = slot,
    // 2 = ACK delimiter, 3..9 = end of frame, 10..12 = intermission),
    // drive, ack, nack, form, ackerr, done_idx, idle_idx}; index 15 = never.
    localparam int NV = 11;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {1'b0, 1'b1, 13'b111_1111111_1_1_1, 1'b1, 4'b1000, 4'd9,  4'd12}, // R3 R4
        {1'b0, 1'b0, 13'b111_1111111_1_1_1, 1'b0, 4'b0100, 4'd9,  4'd12}, // R5
        {1'b0, 1'b0, 13'b111_1111111_1_0_1, 1'b0, 4'b1000, 4'd9,  4'd12}, // R4
        {1'b1, 1'b1, 13'b111_1111111_1_0_1, 1'b0, 4'b1000, 4'd9,  4'd12}, // R4
        {1'b1, 1'b1, 13'b111_1111111_1_1_1, 1'b0, 4'b0101, 4'd15, 4'd2 }, // R7
        {1'b0, 1'b1, 13'b111_1111111_1_1_0, 1'b0, 4'b0010, 4'd15, 4'd0 }, // R2
        {1'b0, 1'b1, 13'b111_1111111_0_1_1, 1'b1, 4'b0010, 4'd15, 4'd2 }, // R6
        {1'b1, 1'b0, 13'b111_1111110_1_0_1, 1'b0, 4'b1010, 4'd15, 4'd3 }, // R8
        {1'b0, 1'b1, 13'b111_0111111_1_1_1, 1'b1, 4'b1010, 4'd15, 4'd9 }, // R8
        {1'b0, 1'b1, 13'b010_1111111_1_1_1, 1'b1, 4'b1000, 4'd9,  4'd12}, // R10
        {1'b0, 1'b0, 13'b111_1110111_1_1_1, 1'b0, 4'b0110, 4'd15, 4'd6 }  // R8
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    int c_ack, c_nack, c_form, c_aerr, c_done, done_at, idle_at;

    // One strobe; then the bus level toggles without a strobe (R11).
    task automatic send_bit(input logic b, input int idx);
        @(negedge clk);
        drv_bit = b; bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        c_ack  += int'(ack_seen);
        c_nack += int'(ack_missing);
        c_form += int'(form_err);
        c_aerr += int'(ack_err);
        c_done += int'(frame_done);
        if (frame_done && done_at == 15) done_at = idx;
        if (bus_idle && idle_at == 15) idle_at = idx;
        drv_bit = ~b;
        @(negedge clk);
        drv_bit = b;
    endtask

    task automatic start_tail(input logic snd, input logic mat);
        @(negedge clk);
        crc_done = 1'b1; is_sender = snd; crc_match = mat;
        @(negedge clk);
        crc_done = 1'b0;
        c_ack = 0; c_nack = 0; c_form = 0; c_aerr = 0; c_done = 0;
        done_at = 15; idle_at = 15;
        check(bus_idle == 1'b0, "R10 idle drop", int'(bus_idle), 0);
        check(ack_drive == 1'b0, "R3 no early drive", int'(ack_drive), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_idle == 1'b1, "R1 bus_idle", int'(bus_idle), 1);
        check({ack_drive, ack_seen, ack_missing, ack_err, form_err, frame_done} == 6'b0,
              "R1 outputs", int'({ack_drive, ack_seen, ack_missing, ack_err, form_err, frame_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [27:0] e;
            logic drive_seen;
            e = VEC[v];
            drive_seen = 1'b0;
            start_tail(e[27], e[26]);
            for (int i = 0; i < 13; i++) begin
                send_bit(e[13 + i], i);
                if (i == 0) drive_seen = ack_drive;
                if (i == 1)
                    check(ack_drive == 1'b0, "R3 drive released", int'(ack_drive), 0);
            end
            check(drive_seen == e[12], "R3 slot drive", int'(drive_seen), int'(e[12]));
            check(c_ack  == int'(e[11]), "R4 ack_seen", c_ack, int'(e[11]));
            check(c_nack == int'(e[10]), "R5 ack_missing", c_nack, int'(e[10]));
            check(c_form == int'(e[9]),  "R2 R6 R8 form_err", c_form, int'(e[9]));
            check(c_aerr == int'(e[8]),  "R7 ack_err", c_aerr, int'(e[8]));
            check(done_at == int'(e[7:4]), "R9 done index", done_at, int'(e[7:4]));
            check(c_done == ((e[7:4] == 4'd15) ? 0 : 1), "R9 done count", c_done,
                  (e[7:4] == 4'd15) ? 0 : 1);
            check(idle_at == int'(e[3:0]), "R10 idle index", idle_at, int'(e[3:0]));
        end

        // R12: crc_done in mid-tail is ignored; tail completes on schedule.
        start_tail(1'b0, 1'b1);
        send_bit(1'b1, 0);
        @(negedge clk);
        crc_done = 1'b1; crc_match = 1'b0; is_sender = 1'b1;
        @(negedge clk);
        crc_done = 1'b0;
        for (int i = 1; i < 13; i++) send_bit(1'b1, i);
        check(c_ack == 1, "R12 verdict kept", c_ack, 1);
        check(done_at == 9, "R12 done index", done_at, 9);
        check(idle_at == 12, "R12 idle index", idle_at, 12);

        // R11: long strobe-free stretch with dominant level, then normal end.
        start_tail(1'b1, 1'b0);
        @(negedge clk); drv_bit = 1'b0;
        repeat (20) @(negedge clk);
        check(bus_idle == 1'b0 && form_err == 1'b0, "R11 no advance",
              int'({bus_idle, form_err}), 0);
        for (int i = 0; i < 13; i++) send_bit((i == 1) ? 1'b0 : 1'b1, i);
        check(c_form == 0, "R11 form_err", c_form, 0);
        check(done_at == 9, "R11 done index", done_at, 9);

        // R1: reset mid-tail returns to idle with quiet outputs.
        start_tail(1'b0, 1'b1);
        send_bit(1'b1, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(bus_idle == 1'b1 && ack_drive == 1'b0, "R1 mid-tail reset",
              int'({bus_idle, ack_drive}), 2);
        rst_n = 1'b1;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule